// File: doc/BRIEF.md
# Crossbar Select Latch Serial Read-Back Scanner

This block gives a serial view of the committed routing state of a crossbar. Each output slice of the crossbar holds an active select word, and the scanner shares the serial clock and the serial data pin of the programming port. The serial clock reaches the block as `bit_tick`, a one-cycle strobe in the system clock domain. A strobe counts only while serial mode (`serial_en`) is on. A counted strobe with the scan line (`scan_en`) low takes a snapshot of every committed select word. Each counted strobe with `scan_en` high then moves the scan one bit along a fixed 483-bit chain. Only committed latches are read, never staged values.

The chain holds 69 seven-bit words. Slice 36 is the monitor channel and comes first. The slices then follow in falling order down to slice 0. Inside a word the select bits go out most significant first, with a constant low bit placed between select bit 2 and select bit 1. Words alternate in runs of four carrying words and four padding words, and padding words read as zero. Four-and-four runs over 69 words leave room for only 36 slices, so the final word of the chain is also a carrying word, and slice 0 lands there. While `scan_en` is low, the serial pin carries the programming pass-through instead: `sdin` delayed by 14 counted strobes.

A sequencer runs three named states. ST_IDLE is the state after reset, before any snapshot. ST_SHIFT means chain bits are still pending. ST_DONE means all 483 bits have gone out. The transition T_CAPTURE goes from any state to ST_SHIFT on a snapshot strobe and points at chain bit 0. The transition T_LAST goes from ST_SHIFT to ST_DONE on the strobe that shifts out chain bit 482. Reset returns the sequencer to ST_IDLE.

Top module: `scan_readback`

## Requirements
- R1: While `rst_n` is low and after its release, `sdout` is 0, no snapshot is held and the 14-stage pass-through holds zeros.
- R2: Every counted strobe (`bit_tick` and `serial_en` both high) advances the pass-through, whatever the level of `scan_en`. While `scan_en` is low, `sdout` equals the `sdin` value sampled 14 counted strobes earlier, or 0 if there were fewer.
- R3: A counted strobe with `scan_en` low copies all 37 select words from `sel_flat` (slice i in bits [6i+5:6i]) and restarts the scan at chain bit 0. From the next cycle, with `scan_en` high, `sdout` shows that bit.
- R4: Carrying words hold slices in falling order, 36 first and 0 last. Each word goes out as s5, s4, s3, s2, 0, s1, s0, and each counted strobe with `scan_en` high advances one bit.
- R5: The fifth bit of every word (the filler between s2 and s1) reads 0.
- R6: The chain is 483 bits (69 words). Word w, counted from 0, carries a slice when w mod 8 < 4 or w = 68; every other word reads as seven zeros.
- R7: With `scan_en` high, `sdout` is 0 before the first snapshot and after all 483 bits have been shifted, until the next snapshot.
- R8: A `bit_tick` while `serial_en` is low has no effect: the scan position and the pass-through are unchanged.
- R9: Changes on `sel_flat` after a snapshot do not alter the bits being scanned.
- R10: A snapshot in the middle of a scan discards the rest of the old chain and starts the new one from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe marking a serial-clock rising edge |
| serial_en | input | 1 | Serial mode enable; strobes count only when high |
| scan_en | input | 1 | High: scan read-back; low: snapshot on strobe and pass-through on `sdout` |
| sdin | input | 1 | Serial programming data into the pass-through |
| sel_flat | input | 222 | Committed select words, 6 bits per slice, slice 0 in the low bits |
| sdout | output | 1 | Serial data out: read-back bit or pass-through bit |

## Verification
The pass-through advance and the snapshot share the same counted strobe whenever `scan_en` is low, so a single edge both moves `sdin` into the delay line and reloads the chain. The bench drives random `sdin` on snapshot strobes and flips `scan_en` in the middle of a scan. A behavioural model built from queues follows both paths on every clock, and the serial pin is compared against it in each cycle. Recapture in the middle of a scan, changes on `sel_flat` right after a snapshot, and strobes with serial mode off are mixed into the same runs, so the clash between restart and shift is judged bit by bit.

// File: rtl/scan_pkg.sv
package scan_pkg;

    // Read-back sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // nothing captured since reset
        ST_SHIFT = 2'd1,   // chain bits pending
        ST_DONE  = 2'd2    // chain fully shifted out
    } rd_state_e;

endpackage

// File: rtl/scan_passthru.sv
// Fixed-depth delay line for serial programming data.
module scan_passthru #(
    parameter int DEPTH = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic din,
    output logic tail
);

    logic [DEPTH-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else if (adv) begin
            pipe_q <= {pipe_q[DEPTH-2:0], din};
        end
    end

    assign tail = pipe_q[DEPTH-1];

endmodule

// File: rtl/scan_snapshot.sv
// Parallel snapshot of all committed select words, read one slice at a time.
module scan_snapshot #(
    parameter  int NUM_SLICES = 37,
    parameter  int SEL_W      = 6,
    localparam int SL_W       = $clog2(NUM_SLICES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cap_ev,
    input  logic [NUM_SLICES*SEL_W-1:0] sel_flat,
    input  logic [SL_W-1:0]             rd_idx,
    output logic [SEL_W-1:0]            rd_sel
);

    logic [SEL_W-1:0] slot_q [NUM_SLICES];

    generate
        for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slot_q[g] <= '0;
                end else if (cap_ev) begin
                    slot_q[g] <= sel_flat[g*SEL_W +: SEL_W];
                end
            end
        end
    endgenerate

    always_comb begin
        rd_sel = '0;
        if (rd_idx < SL_W'(NUM_SLICES)) begin
            rd_sel = slot_q[rd_idx];
        end
    end

endmodule

// File: rtl/scan_seq.sv
// Read-back sequencer: chain position, word pattern and slice order.
module scan_seq
    import scan_pkg::*;
#(
    parameter  int NUM_SLICES  = 37,
    parameter  int WORD_W      = 7,
    parameter  int CHAIN_WORDS = 69,
    parameter  int VALID_RUN   = 4,
    parameter  int PAD_RUN     = 4,
    localparam int CHAIN_BITS  = CHAIN_WORDS * WORD_W,
    localparam int PERIOD      = VALID_RUN + PAD_RUN,
    localparam int IDX_W       = $clog2(CHAIN_BITS + 1),
    localparam int BP_W        = $clog2(WORD_W),
    localparam int WI_W        = $clog2(CHAIN_WORDS + 1),
    localparam int PH_W        = $clog2(PERIOD),
    localparam int SL_W        = $clog2(NUM_SLICES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_ev,
    input  logic             shf_ev,
    output rd_state_e        state,
    output logic [IDX_W-1:0] bit_idx,
    output logic [BP_W-1:0]  bit_pos,
    output logic             word_live,
    output logic [SL_W-1:0]  slice_sel
);

    rd_state_e        st_q, st_nx;
    logic [IDX_W-1:0] idx_q;
    logic [BP_W-1:0]  pos_q;
    logic [WI_W-1:0]  word_q;
    logic [PH_W-1:0]  phase_q;
    logic [SL_W-1:0]  done_slices_q;
    logic             last_bit;
    logic             step;

    assign last_bit = (idx_q == IDX_W'(CHAIN_BITS - 1));
    assign step     = shf_ev && (st_q == ST_SHIFT);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nx;
        end
    end

    // next state: T_CAPTURE and T_LAST
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (cap_ev) st_nx = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (cap_ev)                st_nx = ST_SHIFT;
                else if (shf_ev && last_bit) st_nx = ST_DONE;
            end
            ST_DONE: begin
                if (cap_ev) st_nx = ST_SHIFT;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // chain position counters
    always_ff @(posedge clk) begin
        if (!rst_n || cap_ev) begin
            idx_q         <= '0;
            pos_q         <= '0;
            word_q        <= '0;
            phase_q       <= '0;
            done_slices_q <= '0;
        end else if (step) begin
            idx_q <= idx_q + 1'b1;
            if (pos_q == BP_W'(WORD_W - 1)) begin
                pos_q   <= '0;
                word_q  <= word_q + 1'b1;
                phase_q <= (phase_q == PH_W'(PERIOD - 1)) ? '0 : phase_q + 1'b1;
                if (word_live) begin
                    done_slices_q <= done_slices_q + 1'b1;
                end
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        state     = st_q;
        bit_idx   = idx_q;
        bit_pos   = pos_q;
        word_live = ((phase_q < PH_W'(VALID_RUN)) ||
                     (word_q == WI_W'(CHAIN_WORDS - 1))) &&
                    (done_slices_q < SL_W'(NUM_SLICES));
        slice_sel = SL_W'(NUM_SLICES - 1) - done_slices_q;
    end

endmodule

// File: rtl/scan_readback.sv
// Top: serial read-back of committed crossbar select words.
module scan_readback
    import scan_pkg::*;
#(
    parameter  int NUM_SLICES  = 37,
    parameter  int SEL_W       = 6,
    parameter  int CHAIN_WORDS = 69,
    parameter  int VALID_RUN   = 4,
    parameter  int PAD_RUN     = 4,
    parameter  int FILLER_POS  = 2,
    parameter  int PASS_DEPTH  = 14,
    localparam int WORD_W      = SEL_W + 1,
    localparam int CHAIN_BITS  = CHAIN_WORDS * WORD_W,
    localparam int IDX_W       = $clog2(CHAIN_BITS + 1),
    localparam int BP_W        = $clog2(WORD_W),
    localparam int SL_W        = $clog2(NUM_SLICES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bit_tick,
    input  logic                        serial_en,
    input  logic                        scan_en,
    input  logic                        sdin,
    input  logic [NUM_SLICES*SEL_W-1:0] sel_flat,
    output logic                        sdout
);

    logic             counted;
    logic             cap_ev;
    logic             shf_ev;
    logic             pipe_tail;
    rd_state_e        rd_state;
    logic [IDX_W-1:0] bit_idx;
    logic [BP_W-1:0]  bit_pos;
    logic             word_live;
    logic [SL_W-1:0]  slice_sel;
    logic [SEL_W-1:0] rd_sel;
    logic [WORD_W-1:0] word;
    logic             rb_bit;

    assign counted = bit_tick && serial_en;
    assign cap_ev  = counted && !scan_en;
    assign shf_ev  = counted && scan_en;

    scan_passthru #(
        .DEPTH (PASS_DEPTH)
    ) u_pass (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (counted),
        .din   (sdin),
        .tail  (pipe_tail)
    );

    scan_snapshot #(
        .NUM_SLICES (NUM_SLICES),
        .SEL_W      (SEL_W)
    ) u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_ev   (cap_ev),
        .sel_flat (sel_flat),
        .rd_idx   (slice_sel),
        .rd_sel   (rd_sel)
    );

    scan_seq #(
        .NUM_SLICES  (NUM_SLICES),
        .WORD_W      (WORD_W),
        .CHAIN_WORDS (CHAIN_WORDS),
        .VALID_RUN   (VALID_RUN),
        .PAD_RUN     (PAD_RUN)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_ev    (cap_ev),
        .shf_ev    (shf_ev),
        .state     (rd_state),
        .bit_idx   (bit_idx),
        .bit_pos   (bit_pos),
        .word_live (word_live),
        .slice_sel (slice_sel)
    );

    // word layout: select bits with a constant low filler inserted
    always_comb begin
        word = '0;
        for (int j = 0; j < WORD_W; j++) begin
            if (j < FILLER_POS) begin
                word[j] = rd_sel[j];
            end else if (j > FILLER_POS) begin
                word[j] = rd_sel[j-1];
            end
        end
    end

    assign rb_bit = (rd_state == ST_SHIFT) && word_live &&
                    word[BP_W'(WORD_W - 1) - bit_pos];

    assign sdout = scan_en ? rb_bit : pipe_tail;

endmodule

// File: rtl/scan_readback_chk.sv
// Property checker for scan_readback, attached by bind.
module scan_readback_chk
    import scan_pkg::*;
#(
    parameter  int WORD_W     = 7,
    parameter  int FILLER_POS = 2,
    parameter  int CHAIN_BITS = 483,
    localparam int IDX_W      = $clog2(CHAIN_BITS + 1),
    localparam int BP_W       = $clog2(WORD_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_tick,
    input logic             serial_en,
    input logic             scan_en,
    input logic             sdout,
    input logic             pipe_tail,
    input rd_state_e        rd_state,
    input logic [IDX_W-1:0] bit_idx,
    input logic [BP_W-1:0]  bit_pos
);

    AST_PASS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |-> (sdout == pipe_tail));                                    // R2

    AST_CAPTURE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && serial_en && !scan_en) |=>
        (rd_state == ST_SHIFT && bit_idx == '0));                             // R3

    AST_FILLER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && rd_state == ST_SHIFT &&
         bit_pos == BP_W'(WORD_W - 1 - FILLER_POS)) |-> !sdout);              // R5

    AST_LAST_BIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && serial_en && scan_en && rd_state == ST_SHIFT &&
         bit_idx == IDX_W'(CHAIN_BITS - 1)) |=> (rd_state == ST_DONE));       // R6

    AST_QUIET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && rd_state != ST_SHIFT) |-> !sdout);                        // R7

    AST_IGNORED_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_tick && serial_en) |=>
        ($stable(bit_idx) && $stable(rd_state) && $stable(pipe_tail)));       // R8

endmodule

bind scan_readback scan_readback_chk #(
    .WORD_W     (WORD_W),
    .FILLER_POS (FILLER_POS),
    .CHAIN_BITS (CHAIN_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .serial_en (serial_en),
    .scan_en   (scan_en),
    .sdout     (sdout),
    .pipe_tail (pipe_tail),
    .rd_state  (rd_state),
    .bit_idx   (bit_idx),
    .bit_pos   (bit_pos)
);

// File: tb/scan_readback_tb.sv
module scan_readback_tb;

    localparam int NS    = 37;
    localparam int SW    = 6;
    localparam int WORDS = 69;
    localparam int DEPTH = 14;

    logic          clk       = 1'b0;
    logic          rst_n     = 1'b0;
    logic          bit_tick  = 1'b0;
    logic          serial_en = 1'b0;
    logic          scan_en   = 1'b0;
    logic          sdin      = 1'b0;
    logic [NS*SW-1:0] sel_flat = '0;
    logic          sdout;

    int    checks = 0;
    int    errors = 0;
    int    cyc    = 0;
    bit    done   = 1'b0;
    string cur_req = "R1";

    bit q_pt[$];
    bit q_rb[$];

    always #5 clk = ~clk;

    scan_readback u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .serial_en (serial_en),
        .scan_en   (scan_en),
        .sdin      (sdin),
        .sel_flat  (sel_flat),
        .sdout     (sdout)
    );

    // ---------------- reference model ----------------
    function automatic void model_reset();
        q_pt.delete();
        for (int i = 0; i < DEPTH; i++) q_pt.push_back(1'b0);
        q_rb.delete();
    endfunction

    function automatic void model_capture();
        int k = 0;
        q_rb.delete();
        for (int w = 0; w < WORDS; w++) begin
            bit [6:0] wd = '0;
            if ((w % 8 < 4 || w == WORDS - 1) && k < NS) begin
                logic [5:0] s = sel_flat[(NS-1-k)*SW +: SW];
                wd = {s[5:2], 1'b0, s[1:0]};
                k++;
            end
            for (int b = 6; b >= 0; b--) q_rb.push_back(wd[b]);
        end
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            model_reset();
        end else if (bit_tick && serial_en) begin
            q_pt.push_back(sdin);
            void'(q_pt.pop_front());
            if (!scan_en) model_capture();
            else if (q_rb.size() > 0) void'(q_rb.pop_front());
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        bit exp;
        if (!done) begin
            if (scan_en) exp = (q_rb.size() > 0) ? q_rb[0] : 1'b0;
            else         exp = q_pt[0];
            checks++;
            if (sdout !== exp) begin
                errors++;
                $display("FAIL %s: cycle %0d sdout=%b expected=%b", cur_req, cyc, sdout, exp);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cycle_in(input bit t, input bit se, input bit sc, input bit d);
        @(negedge clk);
        #1;
        bit_tick  = t;
        serial_en = se;
        scan_en   = sc;
        sdin      = d;
    endtask

    task automatic shifts(input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            cycle_in(1'b1, 1'b1, 1'b1, 1'($urandom));
            if (gaps && ($urandom % 3 == 0)) cycle_in(1'b0, 1'b1, 1'b1, 1'b0);
        end
    endtask

    task automatic new_sel(input bit ones_top);
        @(negedge clk);
        #1;
        for (int i = 0; i < NS; i++) sel_flat[i*SW +: SW] = 6'($urandom);
        if (ones_top) sel_flat[(NS-1)*SW +: SW] = 6'h3F;
    endtask

    // ---------------- test sequence ----------------
    initial begin
        model_reset();
        cur_req = "R1";
        repeat (3) cycle_in(1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        repeat (2) cycle_in(1'b0, 1'b0, 1'b0, 1'b0);

        // R7: shifting before any snapshot reads zero
        cur_req = "R7";
        repeat (5) cycle_in(1'b1, 1'b1, 1'b1, 1'b1);

        // R2: pass-through with data on snapshot strobes
        cur_req = "R2";
        for (int i = 0; i < 40; i++) begin
            cycle_in(1'b1, 1'b1, 1'b0, 1'($urandom));
            if (i % 4 == 0) cycle_in(1'b0, 1'b1, 1'b0, 1'b1);
        end

        // R8: strobes with serial mode off are ignored
        cur_req = "R8";
        for (int i = 0; i < 6; i++) cycle_in(1'b1, 1'b0, 1'b0, 1'($urandom));

        // R3/R4/R5/R6: snapshot then scan
        new_sel(1'b1);
        cur_req = "R3";
        cycle_in(1'b1, 1'b1, 1'b0, 1'b1);
        cycle_in(1'b0, 1'b1, 1'b1, 1'b0);
        cur_req = "R4";
        shifts(120, 1'b1);

        // R9: select inputs move after the snapshot
        cur_req = "R9";
        new_sel(1'b0);
        shifts(60, 1'b0);

        // R8: ignored strobes in the middle of a scan
        cur_req = "R8";
        for (int i = 0; i < 5; i++) cycle_in(1'b1, 1'b0, 1'b1, 1'($urandom));

        // R2: peek at the pass-through mid-scan without a strobe
        cur_req = "R2";
        repeat (3) cycle_in(1'b0, 1'b1, 1'b0, 1'b0);

        cur_req = "R6";
        shifts(483 - 180, 1'b0);

        // R7: chain exhausted
        cur_req = "R7";
        shifts(12, 1'b1);

        // R10: recapture in the middle of a scan
        new_sel(1'b0);
        cur_req = "R10";
        cycle_in(1'b1, 1'b1, 1'b0, 1'b0);
        shifts(50, 1'b0);
        new_sel(1'b1);
        cycle_in(1'b1, 1'b1, 1'b0, 1'b1);
        cur_req = "R5";
        shifts(490, 1'b0);

        // R1: reset in the middle of a scan clears everything
        new_sel(1'b0);
        cycle_in(1'b1, 1'b1, 1'b0, 1'b1);
        shifts(20, 1'b0);
        cur_req = "R1";
        rst_n = 1'b0;
        repeat (2) cycle_in(1'b0, 1'b1, 1'b1, 1'b0);
        rst_n = 1'b1;
        repeat (3) cycle_in(1'b1, 1'b1, 1'b1, 1'b1);
        repeat (3) cycle_in(1'b0, 1'b1, 1'b0, 1'b0);

        cycle_in(1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: cycle %0d run did not complete, expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule